// File: doc/BRIEF.md
# Speculative Load Fault Guard

This block screens a speculative load before it reaches memory. It forms the effective address from a base operand and either a displacement operand or an immediate. It then checks that address against the natural alignment of the access size, and checks that the target register lines up with a register pair or a register quad for the wide sizes. A fault never raises a trap. Instead, the block sets a deferred-fault flag on the target register. It keeps one flag vector for the general registers and a separate one for the floating-point registers.

When no fault is found, the target register inherits the deferred-fault state of its source registers. If a source is already marked, the load is suppressed and the mark moves on to the target. This lets a chain of dependent speculative loads carry one failure forward without trapping. When recording is turned on, each accepted load also claims a slot in a small pool of status records. The slot keeps the load's attributes, its fault codes and its effective address for later inspection.

The register values and the memory access itself stay outside the block. The operand values come in as inputs, and the block gives one registered go/no-go answer per request.

Top module: `spec_load_guard`

## Requirements
- R1: The effective address is `base_val_i + disp_val_i` when `use_disp_i` is 1, and `base_val_i + imm_val_i` otherwise, modulo 2^AW. It is observed in the address record of a written slot.
- R2: The size codes are: 0 and 1 for byte, 2 and 3 for halfword, 4 for word, 5 for doubleword, 6 for quadword. A byte access never misaligns. Halfword faults when address bit 0 is set, word when any of bits 1:0 is set, doubleword when any of bits 2:0 is set, and quadword when any of bits 3:0 is set.
- R3: A doubleword access with an odd target index raises a register fault. So does a quadword access whose target index is not a multiple of 4. The other sizes never raise a register fault.
- R4: Either fault sets the target's flag. The flag is set in `fr_ne_o` when `is_fp_i` is 1 and in `gr_ne_o` otherwise, and the other vector is left unchanged. A faulting load still reports `perform_o` = 1.
- R5: Without a fault, the target flag takes the OR of the base flag and, when `use_disp_i` is 1, the displacement flag, all read from the same set. The response is `perform_o` = 0 when that OR is 1, and `perform_o` = 1 otherwise.
- R6: Each request cycle gives exactly one response cycle: `resp_valid_o` is high in the cycle after the request and at no other time. `perform_o`, `size_err_o` and `ovf_err_o` hold valid values only while `resp_valid_o` is high.
- R7: When `rec_en_i` is 1 and the size is valid, the request fills the lowest-index empty slot and sets its bit in `rec_valid_o`. The slot's status, MSB to LSB, is: valid=1, address-valid=1, target index (RIW bits), size code (3 bits), slot index (SIW bits), fp bit, memory-fault bit, register-fault bit. Its address record receives the effective address. Only reset frees a slot.
- R8: The memory-fault bit and the register-fault bit of a status record are set on their own. Each is 1 only when its own fault occurred, so both are 0 for a clean load.
- R9: Size code 7 is unsupported. It gives `size_err_o` = 1 and `perform_o` = 0, and it changes no flag and no slot.
- R10: When recording is requested but all slots are full, the response gives `ovf_err_o` = 1 and no record is written. The flag update still takes place.
- R11: After reset, both flag vectors, `rec_valid_o`, all records and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A load check is requested this cycle |
| base_val_i | input | AW | Base register value |
| disp_val_i | input | AW | Displacement register value |
| imm_val_i | input | AW | Immediate displacement |
| use_disp_i | input | 1 | 1: add the displacement register, 0: add the immediate |
| base_idx_i | input | RIW | Base register index |
| disp_idx_i | input | RIW | Displacement register index |
| tgt_idx_i | input | RIW | Target register index |
| size_i | input | 3 | Access size code |
| is_fp_i | input | 1 | The target is a floating-point register |
| rec_en_i | input | 1 | Write a status and address record |
| resp_valid_o | output | 1 | Response strobe |
| perform_o | output | 1 | The load may proceed |
| size_err_o | output | 1 | Unsupported size code |
| ovf_err_o | output | 1 | No free record slot |
| gr_ne_o | output | NREG | General register deferred-fault flags |
| fr_ne_o | output | NREG | FP register deferred-fault flags |
| rec_valid_o | output | NSLOT | Occupied record slots |
| rec_status_o | output | NSLOT*STW | Status records, slot 0 in the LSBs |
| rec_addr_o | output | NSLOT*AW | Address records, slot 0 in the LSBs |

## Verification
The checker watches these properties on every cycle:
- the one-to-one timing between requests and responses;
- that an unsupported size leaves both flag vectors and the slot pool untouched;
- that slots only fill, at most one per cycle, and stay filled;
- that an overflow is reported only while the pool is full.

The bench's scenarios are needed for the properties that depend on data:
- the per-size masks for address and register alignment;
- that a flag propagates through a base or displacement source while the other flag set stays untouched;
- lowest-free slot choice and the exact packing of status fields;
- the effective address for each operand choice.

// File: rtl/slg_pkg.sv
package slg_pkg;

   typedef enum logic [2:0] {
      SZ_UB   = 3'd0,
      SZ_SB   = 3'd1,
      SZ_UH   = 3'd2,
      SZ_SH   = 3'd3,
      SZ_WD   = 3'd4,
      SZ_DW   = 3'd5,
      SZ_QW   = 3'd6,
      SZ_NONE = 3'd7
   } size_e;

   // Low address bits that must be zero for a naturally aligned access.
   function automatic logic [3:0] addr_mask(size_e sz);
      case (sz)
         SZ_UH, SZ_SH: addr_mask = 4'b0001;
         SZ_WD:        addr_mask = 4'b0011;
         SZ_DW:        addr_mask = 4'b0111;
         SZ_QW:        addr_mask = 4'b1111;
         default:      addr_mask = 4'b0000;
      endcase
   endfunction

   // Low target-index bits that must be zero for pair and quad targets.
   function automatic logic [1:0] regs_mask(size_e sz);
      case (sz)
         SZ_DW:   regs_mask = 2'b01;
         SZ_QW:   regs_mask = 2'b11;
         default: regs_mask = 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/slg_align.sv
module slg_align
   import slg_pkg::*;
#(
   parameter int AW  = 32,
   parameter int RIW = 6
) (
   input  logic [AW-1:0]  base_i,
   input  logic [AW-1:0]  disp_i,
   input  logic [AW-1:0]  imm_i,
   input  logic           use_disp_i,
   input  logic [2:0]     size_i,
   input  logic [RIW-1:0] tgt_i,
   output logic [AW-1:0]  ea_o,
   output logic           mem_flt_o,
   output logic           reg_flt_o,
   output logic           size_bad_o
);

   size_e sz;

   assign sz         = size_e'(size_i);
   assign ea_o       = base_i + (use_disp_i ? disp_i : imm_i);
   assign mem_flt_o  = |(ea_o[3:0] & addr_mask(sz));
   assign reg_flt_o  = |(tgt_i[1:0] & regs_mask(sz));
   assign size_bad_o = (sz == SZ_NONE);

endmodule

// File: rtl/slg_flags.sv
module slg_flags #(
   parameter int NREG = 64,
   parameter int RIW  = 6
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            upd_i,
   input  logic            is_fp_i,
   input  logic            fault_i,
   input  logic            use_disp_i,
   input  logic [RIW-1:0]  base_idx_i,
   input  logic [RIW-1:0]  disp_idx_i,
   input  logic [RIW-1:0]  tgt_idx_i,
   output logic            src_flag_o,
   output logic [NREG-1:0] gr_o,
   output logic [NREG-1:0] fr_o
);

   localparam int NBANK = 2;

   logic [NBANK-1:0][NREG-1:0] ne_q;
   logic [NREG-1:0]            sel;

   assign sel        = ne_q[is_fp_i];
   assign src_flag_o = sel[base_idx_i] | (use_disp_i & sel[disp_idx_i]);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ne_q[b] <= '0;
         end else if (upd_i && (is_fp_i == 1'(b))) begin
            ne_q[b][tgt_idx_i] <= fault_i | src_flag_o;
         end
      end
   end

   assign gr_o = ne_q[0];
   assign fr_o = ne_q[1];

endmodule

// File: rtl/slg_records.sv
module slg_records #(
   parameter int NSLOT = 4,
   parameter int AW    = 32,
   parameter int RIW   = 6,
   parameter int SIW   = 2,
   parameter int STW   = RIW + SIW + 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_i,
   input  logic [RIW-1:0]       tgt_i,
   input  logic [2:0]           size_i,
   input  logic                 fp_i,
   input  logic                 mem_flt_i,
   input  logic                 reg_flt_i,
   input  logic [AW-1:0]        addr_i,
   output logic                 ovf_o,
   output logic [NSLOT-1:0]     valid_o,
   output logic [NSLOT*STW-1:0] status_o,
   output logic [NSLOT*AW-1:0]  addr_o
);

   logic [NSLOT-1:0]          vld_q;
   logic [NSLOT-1:0][STW-1:0] st_q;
   logic [NSLOT-1:0][AW-1:0]  ad_q;
   logic [SIW-1:0]            pick;
   logic                      found;

   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         if (!vld_q[i] && !found) begin
            pick  = SIW'(i);
            found = 1'b1;
         end
      end
   end

   assign ovf_o = wr_i & ~found;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q <= '0;
         st_q  <= '0;
         ad_q  <= '0;
      end else if (wr_i && found) begin
         vld_q[pick] <= 1'b1;
         st_q[pick]  <= {1'b1, 1'b1, tgt_i, size_i, pick, fp_i, mem_flt_i, reg_flt_i};
         ad_q[pick]  <= addr_i;
      end
   end

   assign valid_o  = vld_q;
   assign status_o = st_q;
   assign addr_o   = ad_q;

endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard #(
   parameter int AW    = 32,
   parameter int NREG  = 64,
   parameter int NSLOT = 4,
   localparam int RIW  = $clog2(NREG),
   localparam int SIW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int STW  = RIW + SIW + 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 req_valid_i,
   input  logic [AW-1:0]        base_val_i,
   input  logic [AW-1:0]        disp_val_i,
   input  logic [AW-1:0]        imm_val_i,
   input  logic                 use_disp_i,
   input  logic [RIW-1:0]       base_idx_i,
   input  logic [RIW-1:0]       disp_idx_i,
   input  logic [RIW-1:0]       tgt_idx_i,
   input  logic [2:0]           size_i,
   input  logic                 is_fp_i,
   input  logic                 rec_en_i,
   output logic                 resp_valid_o,
   output logic                 perform_o,
   output logic                 size_err_o,
   output logic                 ovf_err_o,
   output logic [NREG-1:0]      gr_ne_o,
   output logic [NREG-1:0]      fr_ne_o,
   output logic [NSLOT-1:0]     rec_valid_o,
   output logic [NSLOT*STW-1:0] rec_status_o,
   output logic [NSLOT*AW-1:0]  rec_addr_o
);

   if (AW < 4) begin : g_bad_aw
      $error("spec_load_guard: AW must cover the quadword alignment bits");
   end
   if (NREG < 4 || (1 << RIW) != NREG) begin : g_bad_nreg
      $error("spec_load_guard: NREG must be a power of two, at least 4");
   end
   if (NSLOT < 1 || NSLOT > 16) begin : g_bad_nslot
      $error("spec_load_guard: NSLOT must lie in 1..16");
   end

   logic [AW-1:0] ea;
   logic          mem_flt, reg_flt, size_bad, fault, src_flag;
   logic          upd, rec_wr, ovf_hit;
   logic          resp_q, perform_q, serr_q, ovf_q;

   slg_align #(.AW(AW), .RIW(RIW)) u_align (
      .base_i     (base_val_i),
      .disp_i     (disp_val_i),
      .imm_i      (imm_val_i),
      .use_disp_i (use_disp_i),
      .size_i     (size_i),
      .tgt_i      (tgt_idx_i),
      .ea_o       (ea),
      .mem_flt_o  (mem_flt),
      .reg_flt_o  (reg_flt),
      .size_bad_o (size_bad)
   );

   assign fault  = mem_flt | reg_flt;
   assign upd    = req_valid_i & ~size_bad;
   assign rec_wr = upd & rec_en_i;

   slg_flags #(.NREG(NREG), .RIW(RIW)) u_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .upd_i      (upd),
      .is_fp_i    (is_fp_i),
      .fault_i    (fault),
      .use_disp_i (use_disp_i),
      .base_idx_i (base_idx_i),
      .disp_idx_i (disp_idx_i),
      .tgt_idx_i  (tgt_idx_i),
      .src_flag_o (src_flag),
      .gr_o       (gr_ne_o),
      .fr_o       (fr_ne_o)
   );

   slg_records #(.NSLOT(NSLOT), .AW(AW), .RIW(RIW), .SIW(SIW), .STW(STW)) u_recs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (rec_wr),
      .tgt_i     (tgt_idx_i),
      .size_i    (size_i),
      .fp_i      (is_fp_i),
      .mem_flt_i (mem_flt),
      .reg_flt_i (reg_flt),
      .addr_i    (ea),
      .ovf_o     (ovf_hit),
      .valid_o   (rec_valid_o),
      .status_o  (rec_status_o),
      .addr_o    (rec_addr_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         resp_q    <= 1'b0;
         perform_q <= 1'b0;
         serr_q    <= 1'b0;
         ovf_q     <= 1'b0;
      end else begin
         resp_q    <= req_valid_i;
         perform_q <= upd & (fault | ~src_flag);
         serr_q    <= req_valid_i & size_bad;
         ovf_q     <= ovf_hit;
      end
   end

   assign resp_valid_o = resp_q;
   assign perform_o    = perform_q;
   assign size_err_o   = serr_q;
   assign ovf_err_o    = ovf_q;

endmodule

// File: rtl/slg_checker.sv
module slg_checker #(
   parameter int NREG  = 64,
   parameter int NSLOT = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             req_valid_i,
   input logic [2:0]       size_i,
   input logic             resp_valid_o,
   input logic             perform_o,
   input logic             size_err_o,
   input logic             ovf_err_o,
   input logic [NREG-1:0]  gr_ne_o,
   input logic [NREG-1:0]  fr_ne_o,
   input logic [NSLOT-1:0] rec_valid_o
);

   // R6
   a_r6_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> resp_valid_o);

   // R6
   a_r6_no_spurious_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !resp_valid_o);

   // R9
   a_r9_bad_size_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && size_i == 3'd7) |=>
         (size_err_o && !perform_o && $stable(gr_ne_o) && $stable(fr_ne_o)
          && $stable(rec_valid_o)));

   // R9
   a_r9_err_only_with_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (size_err_o || ovf_err_o || perform_o) |-> resp_valid_o);

   // R10
   a_r10_overflow_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_err_o |-> (&rec_valid_o));

   // R7
   a_r7_one_slot_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(rec_valid_o) <= $past($countones(rec_valid_o)) + 1);

   // R7
   a_r7_slots_stay_filled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rec_valid_o) & ~rec_valid_o) == '0);

endmodule

bind spec_load_guard slg_checker #(.NREG(NREG), .NSLOT(NSLOT)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_valid_i  (req_valid_i),
   .size_i       (size_i),
   .resp_valid_o (resp_valid_o),
   .perform_o    (perform_o),
   .size_err_o   (size_err_o),
   .ovf_err_o    (ovf_err_o),
   .gr_ne_o      (gr_ne_o),
   .fr_ne_o      (fr_ne_o),
   .rec_valid_o  (rec_valid_o)
);

// File: tb/test_spec_load_guard.sv
`timescale 1ns/1ps
module test_spec_load_guard;

   localparam int AW    = 32;
   localparam int NREG  = 64;
   localparam int NSLOT = 4;
   localparam int RIW   = 6;
   localparam int SIW   = 2;
   localparam int STW   = 16;

   typedef struct {
      logic                 perform;
      logic                 serr;
      logic                 oerr;
      logic [NREG-1:0]      g;
      logic [NREG-1:0]      f;
      logic [NSLOT-1:0]     rv;
      logic [NSLOT*STW-1:0] st;
      logic [NSLOT*AW-1:0]  ad;
      string                tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] base_v = '0, disp_v = '0, imm_v = '0;
   logic use_disp = 1'b0;
   logic [RIW-1:0] b_idx = '0, d_idx = '0, t_idx = '0;
   logic [2:0] size = '0;
   logic is_fp = 1'b0, rec_en = 1'b0;

   logic                 resp_valid, perform, size_err, ovf_err;
   logic [NREG-1:0]      gr_ne, fr_ne;
   logic [NSLOT-1:0]     rec_valid;
   logic [NSLOT*STW-1:0] rec_status;
   logic [NSLOT*AW-1:0]  rec_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   exp_t q[$];

   logic [NREG-1:0]      gm = '0, fm = '0;
   logic [NSLOT-1:0]     vm = '0;
   logic [NSLOT*STW-1:0] sm = '0;
   logic [NSLOT*AW-1:0]  am = '0;

   always #2.5 clk = ~clk;

   spec_load_guard #(.AW(AW), .NREG(NREG), .NSLOT(NSLOT)) i_spec_load_guard (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_valid_i  (req_valid),
      .base_val_i   (base_v),
      .disp_val_i   (disp_v),
      .imm_val_i    (imm_v),
      .use_disp_i   (use_disp),
      .base_idx_i   (b_idx),
      .disp_idx_i   (d_idx),
      .tgt_idx_i    (t_idx),
      .size_i       (size),
      .is_fp_i      (is_fp),
      .rec_en_i     (rec_en),
      .resp_valid_o (resp_valid),
      .perform_o    (perform),
      .size_err_o   (size_err),
      .ovf_err_o    (ovf_err),
      .gr_ne_o      (gr_ne),
      .fr_ne_o      (fr_ne),
      .rec_valid_o  (rec_valid),
      .rec_status_o (rec_status),
      .rec_addr_o   (rec_addr)
   );

   task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // Driver: applies one request and pushes what the requirements predict.
   task automatic send(input logic [AW-1:0] bv, dv, iv, input logic ud,
                       input int bi, di, ti, input logic [2:0] sz,
                       input logic fp, rec, input string tag);
      exp_t e;
      logic [AW-1:0] ea;
      logic mm, rr, src, found;
      int slot;
      @(negedge clk);
      req_valid = 1'b1; base_v = bv; disp_v = dv; imm_v = iv; use_disp = ud;
      b_idx = RIW'(bi); d_idx = RIW'(di); t_idx = RIW'(ti); size = sz;
      is_fp = fp; rec_en = rec;
      ea = ud ? bv + dv : bv + iv;
      case (sz)
         3'd2, 3'd3: mm = ea[0];
         3'd4:       mm = |ea[1:0];
         3'd5:       mm = |ea[2:0];
         3'd6:       mm = |ea[3:0];
         default:    mm = 1'b0;
      endcase
      rr = (sz == 3'd5) ? t_idx[0] : (sz == 3'd6) ? |t_idx[1:0] : 1'b0;
      e.serr = (sz == 3'd7);
      e.oerr = 1'b0;
      e.perform = 1'b0;
      if (!e.serr) begin
         if (fp) src = fm[bi] | (ud & fm[di]);
         else    src = gm[bi] | (ud & gm[di]);
         e.perform = mm | rr | !src;
         if (fp) fm[ti] = mm | rr | src;
         else    gm[ti] = mm | rr | src;
         if (rec) begin
            found = 1'b0; slot = 0;
            for (int i = 0; i < NSLOT; i++)
               if (!vm[i] && !found) begin found = 1'b1; slot = i; end
            if (!found) e.oerr = 1'b1;
            else begin
               vm[slot] = 1'b1;
               sm[slot*STW +: STW] = {1'b1, 1'b1, t_idx, sz, SIW'(slot), fp, mm, rr};
               am[slot*AW +: AW] = ea;
            end
         end
      end
      e.g = gm; e.f = fm; e.rv = vm; e.st = sm; e.ad = am; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; rec_en = 1'b0;
   endtask

   // Monitor: compares each response with the oldest expectation.
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R6", "unexpected response", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(perform == e.perform, e.tag, "perform", perform, e.perform);
            chk(size_err == e.serr, e.tag, "size_err", size_err, e.serr);
            chk(ovf_err == e.oerr, e.tag, "ovf_err", ovf_err, e.oerr);
            chk(gr_ne == e.g, e.tag, "gr flags", gr_ne, e.g);
            chk(fr_ne == e.f, e.tag, "fr flags", fr_ne, e.f);
            chk(rec_valid == e.rv, e.tag, "slot valid", rec_valid, e.rv);
            chk(rec_status == e.st, e.tag, "status records", rec_status, e.st);
            chk(rec_addr == e.ad, e.tag, "address records", rec_addr, e.ad);
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(resp_valid == 0 && perform == 0 && size_err == 0 && ovf_err == 0,
          "R11", "response outputs", {resp_valid, perform, size_err, ovf_err}, 0);
      chk(gr_ne == 0 && fr_ne == 0, "R11", "flags", gr_ne | fr_ne, 0);
      chk(rec_valid == 0 && rec_status == 0 && rec_addr == 0, "R11", "records",
          rec_valid, 0);

      send(32'h1000, 32'h20, 0, 1, 1, 2, 3, 3'd4, 0, 0, "R1 R5 clean word");
      send(32'h2001, 0, 0, 0, 1, 0, 4, 3'd2, 0, 0, "R2 R4 halfword misaligned");
      send(32'h3000, 0, 0, 0, 4, 0, 5, 3'd4, 0, 0, "R5 base flag propagates");
      send(32'h3000, 32'h8, 0, 1, 1, 5, 6, 3'd5, 0, 0, "R5 displacement flag propagates");
      send(32'h3000, 0, 0, 0, 1, 0, 5, 3'd4, 0, 0, "R5 flag cleared");
      send(32'h40, 0, 0, 0, 1, 0, 7, 3'd5, 1, 0, "R3 R4 odd pair target fp");
      send(32'h40, 0, 0, 0, 1, 0, 10, 3'd6, 1, 0, "R3 quad target not multiple of 4");
      send(32'h48, 0, 0, 0, 1, 0, 12, 3'd6, 1, 0, "R2 quad misaligned");
      send(32'h1003, 0, 0, 0, 1, 0, 8, 3'd0, 0, 0, "R2 byte never faults");
      send(32'h1002, 0, 0, 0, 1, 0, 9, 3'd3, 0, 0, "R2 signed half aligned");
      send(32'h1001, 0, 0, 0, 4, 0, 9, 3'd7, 0, 1, "R9 unsupported size");
      send(32'h100, 32'h4, 0, 1, 1, 2, 11, 3'd4, 0, 1, "R7 R8 R1 first slot");
      send(32'h201, 0, 32'h2, 0, 1, 0, 13, 3'd2, 0, 1, "R7 R8 memory fault code");
      send(32'h400, 0, 32'h10, 0, 1, 0, 15, 3'd5, 1, 1, "R7 R8 R3 register fault code");
      send(32'h500, 32'h3, 0, 1, 1, 2, 16, 3'd6, 1, 1, "R7 R1 last slot");
      send(32'h600, 0, 0, 0, 4, 0, 17, 3'd4, 0, 1, "R10 overflow keeps flag update");
      idle();
      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R6", "missing responses", q.size(), 0);
      done = 1'b1;
      finish_run();
   end

endmodule